// File: doc/BRIEF.md
# Consumer-Electronics Control Bus Frame Transmitter

This block sends one message of one to sixteen bytes on a single-wire, open-drain control bus. The user places the message bytes, the byte count and a signal-free-time request on the inputs. The user then pulses `tx_go`. The block waits until the line has been continuously high for the requested number of nominal bit periods. It then drives the start bit, and then ten bit slots per byte: eight data bits, an end-of-message flag and an acknowledge slot. The line is driven through an active-high pull-low enable. The block reads the line back through `line_in`.

While it sends, the block watches the wire. In the first four bits it compares what it released with what it reads, to detect lost arbitration. In every acknowledge slot it samples the line to learn whether the message was accepted. At the end of each data slot it checks whether another node is holding the line low to signal an error. When the transfer ends, `tx_done` pulses for one cycle and `tx_result` gives the outcome. All timing counts the `tick_us` enable, which is nominally one pulse per microsecond. Retries and address handling stay with the caller.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `line_pull`, `tx_busy` and `tx_done` are all 0.
- R2: The start bit drives the line low for START_LOW_US ticks, and the first data slot begins START_TOTAL_US ticks after the start-bit falling edge.
- R3: Each byte goes out as ten slots of BIT_TOTAL_US ticks each. A 0 is driven low for ZERO_LOW_US ticks and a 1 for ONE_LOW_US ticks. Slots 0 to 7 carry the byte MSB first, with byte i taken from `tx_bytes[8*i+7:8*i]`. Slot 8 is 1 only on the final byte. Slot 9, the acknowledge slot, is always sent as 1.
- R4: The acknowledge slot is sampled SAMPLE_US ticks after its falling edge. When the low nibble of byte 0 is 4'hF the message is a broadcast, and a high line means acknowledged. Otherwise a low line means acknowledged.
- R5: On a missing acknowledge, the block sends nothing after that acknowledge slot's full period, and it ends with `tx_result` = 1 (NACK).
- R6: A 1 sent in one of the first four slots of byte 0 is sampled at SAMPLE_US ticks. If the line reads low, the block ends with `tx_result` = 2 (arbitration lost), leaves the line released and sends no further slot.
- R7: If the line is still low when a data slot's period ends, the block pulses `tx_done` with `tx_result` = 3 (low drive). It keeps `tx_busy` high until the line reads high, and then becomes idle.
- R8: The first falling edge comes only after the line has been high for `tx_sft` x BIT_TOTAL_US consecutive ticks after the request was accepted.
- R9: A low line during the wait restarts the count. It also lowers the pending signal-free time to NEW_INIT_SFT periods when the request was larger.
- R10: After the acknowledge slot of the last byte completes without error, the block ends with `tx_result` = 0 (OK).
- R11: A `tx_go` pulse while `tx_busy` is high is ignored. The frame in progress is unchanged, and no second frame follows.
- R12: `tx_done` is a one-cycle pulse. `tx_result` holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | Timing enable, one pulse per microsecond |
| tx_go | input | 1 | Request pulse, accepted only when idle |
| tx_len | input | LEN_W | Number of bytes, 1..MAX_BYTES, held while busy |
| tx_bytes | input | 8*MAX_BYTES | Message bytes, byte 0 in bits 7:0, held while busy |
| tx_sft | input | SFT_W | Requested signal-free time in bit periods |
| line_in | input | 1 | Sampled bus level |
| line_pull | output | 1 | Pull-low enable for the open-drain driver |
| tx_busy | output | 1 | Transfer in progress |
| tx_done | output | 1 | One-cycle completion pulse |
| tx_result | output | 2 | 0 OK, 1 NACK, 2 arbitration lost, 3 low drive |

## Verification
Each slot's low width and its distance from the previous falling edge are measured on `line_pull`. A wrong slot position, a wrong bit value or a wrong timer phase therefore shows up as a miscompare within the same bit period. A stale acknowledge flag, or a sample taken at the wrong tick, shows up as a wrong `tx_result` or as extra slots after the expected stop. These appear at most one bit period after the faulty slot. A wrong signal-free count moves the first falling edge, and it is caught before any bit is sent.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    TXR_OK     = 2'd0,
    TXR_NACK   = 2'd1,
    TXR_ARB    = 2'd2,
    TXR_LOWDRV = 2'd3
  } tx_result_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FREE,
    PH_LOW,
    PH_HIGH,
    PH_DRAIN
  } tx_phase_e;

endpackage

// File: rtl/cec_free_meter.sv
module cec_free_meter #(
  parameter int unsigned BIT_US = 2400,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             line_high,
  output logic [CNT_W-1:0] free_periods
);
  localparam int unsigned UW = (BIT_US > 1) ? $clog2(BIT_US) : 1;

  logic [UW-1:0]    us_q, us_d;
  logic [CNT_W-1:0] per_q, per_d;

  always_comb begin
    us_d  = us_q;
    per_d = per_q;
    if (!enable || !line_high) begin
      us_d  = '0;
      per_d = '0;
    end else if (tick) begin
      if (us_q == UW'(BIT_US - 1)) begin
        us_d = '0;
        if (per_q != {CNT_W{1'b1}}) per_d = per_q + 1'b1;
      end else begin
        us_d = us_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q  <= '0;
      per_q <= '0;
    end else begin
      us_q  <= us_d;
      per_q <= per_d;
    end
  end

  assign free_periods = per_q;

  // R8
  periods_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && line_high) |=> (free_periods >= $past(free_periods)));

endmodule

// File: rtl/cec_slot_timer.sv
module cec_slot_timer #(
  parameter int unsigned TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  output logic [TW-1:0] elapsed
);
  logic [TW-1:0] el_q, el_d;

  always_comb begin
    el_d = el_q;
    if (restart)   el_d = '0;
    else if (tick) el_d = el_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) el_q <= '0;
    else        el_q <= el_d;
  end

  assign elapsed = el_q;

endmodule

// File: rtl/cec_slot_seq.sv
module cec_slot_seq #(
  parameter int unsigned BYTE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic              in_start,
  output logic [BYTE_W-1:0] byte_idx,
  output logic [3:0]        bit_idx
);
  logic              st_q, st_d;
  logic [BYTE_W-1:0] by_q, by_d;
  logic [3:0]        bi_q, bi_d;

  always_comb begin
    st_d = st_q;
    by_d = by_q;
    bi_d = bi_q;
    if (clear) begin
      st_d = 1'b1;
      by_d = '0;
      bi_d = '0;
    end else if (advance) begin
      if (st_q) begin
        st_d = 1'b0;
      end else if (bi_q == 4'd9) begin
        bi_d = '0;
        by_d = by_q + 1'b1;
      end else begin
        bi_d = bi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b1;
      by_q <= '0;
      bi_q <= '0;
    end else begin
      st_q <= st_d;
      by_q <= by_d;
      bi_q <= bi_d;
    end
  end

  assign in_start = st_q;
  assign byte_idx = by_q;
  assign bit_idx  = bi_q;

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd9);

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int unsigned MAX_BYTES      = 16,
  parameter int unsigned START_LOW_US   = 3700,
  parameter int unsigned START_TOTAL_US = 4500,
  parameter int unsigned ZERO_LOW_US    = 1500,
  parameter int unsigned ONE_LOW_US     = 600,
  parameter int unsigned BIT_TOTAL_US   = 2400,
  parameter int unsigned SAMPLE_US      = 850,
  parameter int unsigned NEW_INIT_SFT   = 5,
  parameter int unsigned SFT_W          = 4,
  localparam int unsigned LEN_W         = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   tx_go,
  input  logic [LEN_W-1:0]       tx_len,
  input  logic [MAX_BYTES*8-1:0] tx_bytes,
  input  logic [SFT_W-1:0]       tx_sft,
  input  logic                   line_in,
  output logic                   line_pull,
  output logic                   tx_busy,
  output logic                   tx_done,
  output logic [1:0]             tx_result
);
  localparam int unsigned BYTE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int unsigned T_MAX  = (START_TOTAL_US > BIT_TOTAL_US) ? START_TOTAL_US : BIT_TOTAL_US;
  localparam int unsigned TW     = $clog2(T_MAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  tx_phase_e        phase_q, phase_d;
  logic [SFT_W-1:0] sft_q, sft_d;
  tx_result_e       res_q, res_d;
  logic             done_q, done_d;
  logic             ack_q, ack_d;

  logic              restart, seq_clear, seq_adv;
  logic [TW-1:0]     elapsed, el_inc, low_len, tot_len;
  logic [SFT_W-1:0]  free_periods;
  logic              in_start;
  logic [BYTE_W-1:0] byte_idx;
  logic [3:0]        bit_idx;

  cec_free_meter #(.BIT_US(BIT_TOTAL_US), .CNT_W(SFT_W)) u_free (
    .clk(clk), .rst_n(srst_n), .tick(tick_us),
    .enable(phase_q == PH_FREE), .line_high(line_in),
    .free_periods(free_periods)
  );

  cec_slot_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(srst_n), .tick(tick_us),
    .restart(restart), .elapsed(elapsed)
  );

  cec_slot_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .clear(seq_clear), .advance(seq_adv),
    .in_start(in_start), .byte_idx(byte_idx), .bit_idx(bit_idx)
  );

  // current slot decode
  logic [7:0] cur_byte;
  logic       last_byte, bit_val, is_ack, arb_slot, bcast;
  logic       hit_low, hit_sample, hit_end;

  always_comb begin
    cur_byte  = tx_bytes[{byte_idx, 3'b000} +: 8];
    last_byte = (LEN_W'(byte_idx) + LEN_W'(1)) == tx_len;
    if (bit_idx < 4'd8)       bit_val = cur_byte[3'd7 - bit_idx[2:0]];
    else if (bit_idx == 4'd8) bit_val = last_byte;
    else                      bit_val = 1'b1;
    is_ack   = !in_start && (bit_idx == 4'd9);
    arb_slot = !in_start && (byte_idx == '0) && (bit_idx < 4'd4) && bit_val;
    bcast    = (tx_bytes[3:0] == 4'hF);
    if (in_start)     low_len = TW'(START_LOW_US);
    else if (bit_val) low_len = TW'(ONE_LOW_US);
    else              low_len = TW'(ZERO_LOW_US);
    tot_len    = in_start ? TW'(START_TOTAL_US) : TW'(BIT_TOTAL_US);
    el_inc     = elapsed + 1'b1;
    hit_low    = tick_us && (el_inc == low_len);
    hit_sample = tick_us && (el_inc == TW'(SAMPLE_US));
    hit_end    = tick_us && (el_inc == tot_len);
  end

  // next-state
  always_comb begin
    phase_d   = phase_q;
    sft_d     = sft_q;
    res_d     = res_q;
    ack_d     = ack_q;
    done_d    = 1'b0;
    seq_clear = 1'b0;
    seq_adv   = 1'b0;
    restart   = !(phase_q == PH_LOW || phase_q == PH_HIGH);
    case (phase_q)
      PH_IDLE: begin
        if (tx_go) begin
          phase_d   = PH_FREE;
          sft_d     = tx_sft;
          seq_clear = 1'b1;
        end
      end
      PH_FREE: begin
        if (!line_in) begin
          if (sft_q > SFT_W'(NEW_INIT_SFT)) sft_d = SFT_W'(NEW_INIT_SFT);
        end else if (free_periods >= sft_q) begin
          phase_d = PH_LOW;
          restart = 1'b1;
        end
      end
      PH_LOW: begin
        if (hit_low) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (hit_sample && arb_slot && !line_in) begin
          res_d   = TXR_ARB;
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          if (hit_sample && is_ack) ack_d = bcast ? line_in : !line_in;
          if (hit_end) begin
            if (is_ack && !ack_q) begin
              res_d   = TXR_NACK;
              done_d  = 1'b1;
              phase_d = PH_IDLE;
            end else if (!in_start && !line_in) begin
              res_d   = TXR_LOWDRV;
              done_d  = 1'b1;
              phase_d = PH_DRAIN;
            end else if (is_ack && last_byte) begin
              res_d   = TXR_OK;
              done_d  = 1'b1;
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_LOW;
              restart = 1'b1;
              seq_adv = 1'b1;
            end
          end
        end
      end
      PH_DRAIN: begin
        if (line_in) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_IDLE;
      sft_q   <= '0;
      res_q   <= TXR_OK;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sft_q   <= sft_d;
      res_q   <= res_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
    end
  end

  assign line_pull = (phase_q == PH_LOW);
  assign tx_busy   = (phase_q != PH_IDLE);
  assign tx_done   = done_q;
  assign tx_result = res_q;

  // R2
  pull_window_chk: assert property (@(posedge clk) disable iff (!srst_n)
    line_pull |-> (elapsed < low_len));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tx_done |=> !tx_done);

  // R6
  arb_early_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_done && tx_result == TXR_ARB) |-> (!in_start && byte_idx == '0 && bit_idx < 4'd4));

  // R10
  ok_last_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_done && tx_result == TXR_OK) |-> (bit_idx == 4'd9 && last_byte));

  // R9
  sft_cap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_FREE && !line_in) |=>
      ((sft_q <= SFT_W'(NEW_INIT_SFT)) || (sft_q == $past(sft_q))));

endmodule

// File: tb/cec_frame_tx_test.sv
module cec_frame_tx_test;
  import cec_tx_pkg::*;

  localparam int SL = 37, ST = 45, ZL = 15, OL = 6, BT = 24, SP = 9, NI = 5, MB = 16;
  localparam int LD_LEN = 36;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tick_us = 1'b1;
  logic          tx_go = 1'b0;
  logic [4:0]    tx_len = 5'd1;
  logic [MB*8-1:0] tx_bytes = '0;
  logic [3:0]    tx_sft = 4'd0;
  logic          line_pull, tx_busy, tx_done;
  logic [1:0]    tx_result;
  logic          ext_low = 1'b0;
  logic          force_low = 1'b0;
  logic          line_in;

  assign line_in = !(line_pull || ext_low || force_low);

  cec_frame_tx #(
    .MAX_BYTES(MB), .START_LOW_US(SL), .START_TOTAL_US(ST), .ZERO_LOW_US(ZL),
    .ONE_LOW_US(OL), .BIT_TOTAL_US(BT), .SAMPLE_US(SP), .NEW_INIT_SFT(NI), .SFT_W(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tx_go(tx_go), .tx_len(tx_len),
    .tx_bytes(tx_bytes), .tx_sft(tx_sft), .line_in(line_in), .line_pull(line_pull),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_result(tx_result)
  );

  int vectors = 0;
  int errs = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard queues: one entry per expected slot
  int    exp_low[$];
  int    exp_per[$];
  string exp_tag[$];

  // responder configuration (other nodes on the wire)
  logic [15:0] ack_mask = '0;
  int arb_slot = -1;
  int ld_slot  = -1;

  // responder: counts slots from the falling edges the block makes
  int  resp_slot = 0;
  int  ext_cnt = 0;
  logic pull_d = 1'b0;
  always @(negedge clk) begin : responder
    int s;
    pull_d <= line_pull;
    if (ext_cnt > 0) begin
      ext_cnt <= ext_cnt - 1;
      if (ext_cnt == 1) ext_low <= 1'b0;
    end
    if (!tx_busy) begin
      resp_slot <= 0;
    end else if (line_pull && !pull_d) begin
      s = resp_slot;
      resp_slot <= resp_slot + 1;
      if (s == arb_slot) begin
        ext_low <= 1'b1; ext_cnt <= ZL;
      end else if (s == ld_slot) begin
        ext_low <= 1'b1; ext_cnt <= LD_LEN;
      end else if (s >= 1 && ((s - 1) % 10) == 9 && ack_mask[(s - 1) / 10]) begin
        ext_low <= 1'b1; ext_cnt <= ZL;
      end
    end
  end

  // monitor: measures low width and spacing of each slot
  int   cyc = 0;
  int   last_fall = 0;
  logic mon_prev = 1'b0;
  always @(negedge clk) begin : monitor
    int p, e;
    string t;
    cyc++;
    if (line_pull && !mon_prev) begin
      if (exp_per.size() == 0) begin
        chk(1'b0, cur_req, 1, 0);
      end else begin
        p = exp_per.pop_front();
        t = exp_tag[0];
        if (p != 0) chk((cyc - last_fall) == p, t, cyc - last_fall, p);
      end
      last_fall = cyc;
    end
    if (!line_pull && mon_prev && exp_low.size() != 0) begin
      e = exp_low.pop_front();
      t = exp_tag.pop_front();
      chk((cyc - last_fall) == e, t, cyc - last_fall, e);
    end
    mon_prev = line_pull;
  end

  // driver: pushes the expected slot list, then issues the request
  task automatic start_frame(input int n, input logic [MB*8-1:0] data, input int sft,
                             input int stop_slot, input string req);
    for (int s = 0; s <= stop_slot; s++) begin
      if (s == 0) begin
        exp_low.push_back(SL); exp_per.push_back(0); exp_tag.push_back("R2");
      end else begin
        int b = (s - 1) / 10;
        int k = (s - 1) % 10;
        bit v;
        if (k < 8)       v = data[b*8 + 7 - k];
        else if (k == 8) v = (b == n - 1);
        else             v = 1'b1;
        exp_low.push_back(v ? OL : ZL);
        exp_per.push_back(s == 1 ? ST : BT);
        exp_tag.push_back("R3");
      end
    end
    cur_req = req;
    @(negedge clk);
    tx_len = 5'(n); tx_bytes = data; tx_sft = 4'(sft); tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
  endtask

  task automatic wait_first_fall(output int w);
    w = 0;
    while (!line_pull) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic finish_frame(input tx_result_e exp, input string req, input bit lowdrv);
    int n;
    while (tx_done !== 1'b1) @(negedge clk);
    chk(tx_result == exp, req, tx_result, exp);
    chk(exp_low.size() == 0, req, exp_low.size(), 0);
    if (lowdrv) begin
      chk(tx_busy == 1'b1, "R7", tx_busy, 1);
      n = 0;
      while (tx_busy && n < 200) begin @(negedge clk); n++; end
      chk(tx_busy == 1'b0 && line_in == 1'b1, "R7", tx_busy, 0);
    end else begin
      chk(tx_busy == 1'b0 && line_pull == 1'b0, "R1", {tx_busy, line_pull}, 0);
      @(negedge clk);
      chk(tx_done == 1'b0, "R12", tx_done, 0);
      chk(tx_result == exp, "R12", tx_result, exp);
    end
    repeat (40) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      vectors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    int w;
    logic [MB*8-1:0] d;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(line_pull == 1'b0 && tx_busy == 1'b0 && tx_done == 1'b0, "R1",
        {line_pull, tx_busy, tx_done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(line_pull == 1'b0 && tx_busy == 1'b0, "R1", {line_pull, tx_busy}, 0);

    // R8/R10: directed two-byte frame, both bytes acknowledged
    ack_mask = 16'h0003; arb_slot = -1; ld_slot = -1;
    d = '0; d[7:0] = 8'h40; d[15:8] = 8'hA5;
    start_frame(2, d, 3, 20, "R10");
    wait_first_fall(w);
    chk(w >= 3*BT && w <= 3*BT + 4, "R8", w, 3*BT);
    finish_frame(TXR_OK, "R10", 1'b0);

    // R4: broadcast, line stays high in the acknowledge slot
    ack_mask = 16'h0000;
    d = '0; d[7:0] = 8'h4F;
    start_frame(1, d, 1, 10, "R4");
    finish_frame(TXR_OK, "R4", 1'b0);

    // R4/R5: broadcast rejected by a node pulling the acknowledge slot low
    ack_mask = 16'h0001;
    d = '0; d[7:0] = 8'h4F; d[15:8] = 8'h3C;
    start_frame(2, d, 1, 10, "R5");
    finish_frame(TXR_NACK, "R5", 1'b0);

    // R5: directed, second byte not acknowledged, third never sent
    ack_mask = 16'h0001;
    d = '0; d[7:0] = 8'h40; d[15:8] = 8'h81; d[23:16] = 8'h7E;
    start_frame(3, d, 1, 20, "R5");
    finish_frame(TXR_NACK, "R5", 1'b0);

    // R6: another node sends 0 while this block releases a 1 in slot 2
    ack_mask = 16'h0001; arb_slot = 2;
    d = '0; d[7:0] = 8'h40;
    start_frame(1, d, 1, 2, "R6");
    finish_frame(TXR_ARB, "R6", 1'b0);
    chk(line_pull == 1'b0, "R6", line_pull, 0);
    arb_slot = -1;

    // R7: another node holds the line low across the end of slot 3
    ld_slot = 3;
    start_frame(1, d, 1, 3, "R7");
    finish_frame(TXR_LOWDRV, "R7", 1'b1);
    ld_slot = -1;

    // R3: sixteen-byte frame, end-of-message only on the last byte
    ack_mask = 16'hFFFF;
    d = '0;
    for (int i = 0; i < MB; i++) d[i*8 +: 8] = 8'((i * 37 + 3) & 8'hF0) | 8'(i);
    d[3:0] = 4'h2;
    start_frame(MB, d, 1, MB*10, "R3");
    finish_frame(TXR_OK, "R3", 1'b0);

    // R9: a low line during the wait caps the pending wait at NI periods
    ack_mask = 16'h0001;
    d = '0; d[7:0] = 8'h40;
    start_frame(1, d, 9, 10, "R9");
    repeat (20) @(negedge clk);
    force_low = 1'b1;
    repeat (10) @(negedge clk);
    force_low = 1'b0;
    wait_first_fall(w);
    chk(w >= NI*BT && w <= NI*BT + 4, "R9", w, NI*BT);
    finish_frame(TXR_OK, "R9", 1'b0);

    // R11: a request during a transfer is ignored
    d = '0; d[7:0] = 8'h40; d[15:8] = 8'hFF;
    start_frame(1, d, 1, 10, "R11");
    repeat (100) @(negedge clk);
    tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    finish_frame(TXR_OK, "R11", 1'b0);
    w = 0;
    repeat (300) begin
      @(negedge clk);
      if (tx_busy) w++;
    end
    chk(w == 0, "R11", w, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule